// File: doc/BRIEF.md
# Multicore System Reset Controller

This block sits on a 32-bit register bus. It gives software control over the resets and power state of a four-core processor cluster. The register file has a control word, a reset-status word, an interrupt-status word, an interrupt-mask word, two boot-mode words, two spare words and ten general-purpose words. Only the control word has side effects. All the others are plain storage.

A write to the control word is compared with the stored value, and only the bits that differ have any effect. Toggling a reset bit sends a one-cycle reset request to that core. The bit keeps its written value until the core reports completion, and then the block clears it. Toggling the enable bit of core 1, 2 or 3 sends a one-cycle start or stop request to that core. A start request carries an entry address and an argument taken from that core's pair of general-purpose words. Two display-unit soft-reset bits never hold a changed value and always read back as finished.

Top module: `cluster_reset_ctrl`

## Requirements
- R1: An access is accepted only when bus_addr[1:0] is 0 and bus_be is 4'hF, and the register index is bus_addr[11:2]. A write that is not accepted changes no state. A read that is not accepted returns zero.
- R2: Indices 0 to 17 (byte offsets 0x00 to 0x44) are implemented. A read at offset 0x48 or above returns zero, and a write there changes nothing. Read data appears on bus_rdata in the cycle after the read request.
- R3: After reset the control word (offset 0x00) reads 0x521, the reset-status word (0x08) reads 0x1 and the interrupt-mask word (0x18) reads 0x1F. Every other word reads zero.
- R4: Every word other than the control word stores the full written value and reads it back. Writing such a word raises no core request.
- R5: If a control write changes bit 3 or bit 12 (the display-unit resets), that bit is stored as 0, so it reads back 0.
- R6: If a control write changes bit 13+k (the reset of core k, k = 0..3), core_rst_req[k] pulses high for one cycle in the cycle after the write. The bit then holds its written value until a core_done[k] pulse, and reads 0 from the cycle after that pulse.
- R7: If a control write changes bit 21+k (the enable of core k, k = 1..3) to 1, core_on_req[k] pulses for one cycle. With that pulse, core_entry and core_arg for core k take the values of general-purpose words 2k+1 and 2k+2 (offsets 0x28/0x2C for core 1, 0x30/0x34 for core 2, 0x38/0x3C for core 3). If the bit changes to 0, core_off_req[k] pulses instead.
- R8: If one write changes both the enable and the reset bit of a core, no reset request is sent for that core. Its reset bit then clears on the next core_done pulse.
- R9: From the moment a core's request is issued until its core_done pulse arrives, control writes raise no further request for that core, although the word still stores the written value. A core_done pulse arriving while no request is pending has no effect.
- R10: A control write that leaves the reset and enable bits unchanged raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the 4 KiB window |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| core_done | input | 4 | Per-core completion pulse |
| core_rst_req | output | 4 | Per-core reset request pulse |
| core_on_req | output | 4 | Per-core start request pulse (bit 0 unused, 0) |
| core_off_req | output | 4 | Per-core stop request pulse (bit 0 unused, 0) |
| core_entry | output | 128 | Start address per core, 32 bits each, core k at [32k+31:32k] |
| core_arg | output | 128 | Start argument per core, same layout |

## Verification
The request pulses, core_entry and core_arg come from registers. They are high only in the one cycle after the clock edge that takes the write. The bench drives a write on a falling edge, removes it on the next falling edge and samples the request outputs at that moment, which catches the pulse. Read data is registered as well, so each read is sampled on the falling edge after its request edge. The clearing of a reset bit is seen by a read issued after the core_done pulse has been removed.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_RSTAT = 2;
  localparam int IDX_IMASK = 6;
  localparam int IDX_GPR1  = 8;

  localparam int BIT_CORE_RST0 = 13;
  localparam int BIT_CORE_EN0  = 21;
  localparam int BIT_DISP1     = 3;
  localparam int BIT_DISP2     = 12;

  localparam logic [31:0] CTRL_INIT  = 32'h0000_0521;
  localparam logic [31:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [31:0] IMASK_INIT = 32'h0000_001F;

  function automatic logic [31:0] reg_init(int idx);
    case (idx)
      IDX_CTRL:  return CTRL_INIT;
      IDX_RSTAT: return RSTAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return 32'h0;
    endcase
  endfunction

  // general-purpose word 2k+1 holds the start address of core k
  function automatic int entry_idx(int core);
    return IDX_GPR1 + 2 * core;
  endfunction
endpackage

// File: rtl/rstc_bus_decode.sv
module rstc_bus_decode #(
  parameter int AW    = 12,
  parameter int NREGS = 18
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  output logic          wr_hit,
  output logic          rd_req,
  output logic          rd_hit,
  output logic [AW-3:0] idx
);
  localparam logic [AW-3:0] LIMIT = (AW-2)'(NREGS);

  logic acc_ok;
  logic in_range;

  always_comb begin
    idx      = bus_addr[AW-1:2];
    acc_ok   = bus_sel && (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF);
    in_range = idx < LIMIT;
    wr_hit   = acc_ok && bus_wr && in_range;
    rd_req   = bus_sel && !bus_wr;
    rd_hit   = acc_ok && !bus_wr && in_range;
  end
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int NREGS  = 18,
  parameter int IW     = 10,
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [DW-1:0]        wdata,
  input  logic [IW-1:0]        ridx,
  output logic [DW-1:0]        rval,
  output logic [NCORES*DW-1:0] entry_flat,
  output logic [NCORES*DW-1:0] arg_flat
);
  logic [DW-1:0] mem_q [1:NREGS-1];

  for (genvar i = 1; i < NREGS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        mem_q[i] <= DW'(reg_init(i));
      else if (we && widx == IW'(i))
        mem_q[i] <= wdata;
    end
  end

  always_comb begin
    rval = '0;
    for (int i = 1; i < NREGS; i++)
      if (ridx == IW'(i)) rval = mem_q[i];
  end

  for (genvar k = 0; k < NCORES; k++) begin : g_boot
    if (k == 0 || entry_idx(k) + 1 >= NREGS) begin : g_none
      assign entry_flat[k*DW +: DW] = '0;
      assign arg_flat[k*DW +: DW]   = '0;
    end else begin : g_pair
      assign entry_flat[k*DW +: DW] = mem_q[entry_idx(k)];
      assign arg_flat[k*DW +: DW]   = mem_q[entry_idx(k) + 1];
    end
  end
endmodule

// File: rtl/rstc_core_seq.sv
module rstc_core_seq #(
  parameter int HAS_EN = 1,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          en_chg,
  input  logic          en_new,
  input  logic          rst_chg,
  input  logic          done,
  input  logic [DW-1:0] entry_in,
  input  logic [DW-1:0] arg_in,
  output logic          rst_req,
  output logic          on_req,
  output logic          off_req,
  output logic [DW-1:0] entry,
  output logic [DW-1:0] arg,
  output logic          clr_rst
);
  logic pend;
  logic fire_en, fire_rst;

  always_comb begin
    fire_en  = (HAS_EN != 0) && wr_ctrl && en_chg && !pend;
    fire_rst = wr_ctrl && rst_chg && !en_chg && !pend;
    clr_rst  = pend && done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
      on_req  <= 1'b0;
      off_req <= 1'b0;
      entry   <= '0;
      arg     <= '0;
      pend    <= 1'b0;
    end else begin
      rst_req <= fire_rst;
      on_req  <= fire_en && en_new;
      off_req <= fire_en && !en_new;
      if (fire_en && en_new) begin
        entry <= entry_in;
        arg   <= arg_in;
      end
      if (clr_rst)
        pend <= 1'b0;
      else if (fire_en || fire_rst)
        pend <= 1'b1;
    end
  end

  // R7: a core never sees two kinds of request at once
  a_r7_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_req, on_req, off_req}));

  // R9: a request only starts a fresh pending window
  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (rst_req || on_req || off_req) |-> (pend && !$past(pend)));

  // R6: pending waits for the completion pulse
  a_r6_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    (pend && !done) |=> pend);
endmodule

// File: rtl/cluster_reset_ctrl.sv
module cluster_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NREGS  = 18,
  parameter int NCORES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NCORES-1:0]  core_done,
  output logic [NCORES-1:0]  core_rst_req,
  output logic [NCORES-1:0]  core_on_req,
  output logic [NCORES-1:0]  core_off_req,
  output logic [NCORES*32-1:0] core_entry,
  output logic [NCORES*32-1:0] core_arg
);
  localparam int DW = 32;
  localparam int IW = AW - 2;

  logic          wr_hit, rd_req, rd_hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] reg_rval;
  logic [NCORES*DW-1:0] boot_entry, boot_arg;
  logic [DW-1:0] ctrl_q, ctrl_store, ctrl_n;
  logic [NCORES-1:0] clr;
  logic          wr_ctrl;

  rstc_bus_decode #(.AW(AW), .NREGS(NREGS)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .wr_hit(wr_hit), .rd_req(rd_req), .rd_hit(rd_hit), .idx(idx)
  );

  rstc_regs #(.NREGS(NREGS), .IW(IW), .NCORES(NCORES), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .we(wr_hit && idx != '0), .widx(idx), .wdata(bus_wdata),
    .ridx(idx), .rval(reg_rval),
    .entry_flat(boot_entry), .arg_flat(boot_arg)
  );

  assign wr_ctrl = wr_hit && (idx == '0);

  always_comb begin
    ctrl_store = bus_wdata;
    if (ctrl_q[BIT_DISP1] ^ bus_wdata[BIT_DISP1]) ctrl_store[BIT_DISP1] = 1'b0;
    if (ctrl_q[BIT_DISP2] ^ bus_wdata[BIT_DISP2]) ctrl_store[BIT_DISP2] = 1'b0;
    ctrl_n = wr_ctrl ? ctrl_store : ctrl_q;
    for (int k = 0; k < NCORES; k++)
      if (clr[k]) ctrl_n[BIT_CORE_RST0 + k] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_INIT;
    else     ctrl_q <= ctrl_n;
  end

  for (genvar k = 0; k < NCORES; k++) begin : g_core
    rstc_core_seq #(.HAS_EN(k > 0 ? 1 : 0), .DW(DW)) u_seq (
      .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl),
      .en_chg((k > 0) ? (ctrl_q[BIT_CORE_EN0 + k] ^ bus_wdata[BIT_CORE_EN0 + k]) : 1'b0),
      .en_new(bus_wdata[BIT_CORE_EN0 + k]),
      .rst_chg(ctrl_q[BIT_CORE_RST0 + k] ^ bus_wdata[BIT_CORE_RST0 + k]),
      .done(core_done[k]),
      .entry_in(boot_entry[k*DW +: DW]), .arg_in(boot_arg[k*DW +: DW]),
      .rst_req(core_rst_req[k]), .on_req(core_on_req[k]), .off_req(core_off_req[k]),
      .entry(core_entry[k*DW +: DW]), .arg(core_arg[k*DW +: DW]),
      .clr_rst(clr[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (rd_req)
      bus_rdata <= !rd_hit ? '0 : (idx == '0) ? ctrl_q : reg_rval;
  end

  // R5: a changed display-unit bit never lands in the stored word
  a_r5_disp_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && (ctrl_q[BIT_DISP1] ^ bus_wdata[BIT_DISP1])) |=> !ctrl_q[BIT_DISP1]);

  // R1: a rejected write leaves the control word alone
  a_r1_bad_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && (bus_addr[1:0] != 2'b00 || bus_be != 4'hF) && clr == '0)
      |=> $stable(ctrl_q));
endmodule

// File: tb/cluster_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module cluster_reset_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  core_done = '0;
  logic [3:0]  core_rst_req, core_on_req, core_off_req;
  logic [127:0] core_entry, core_arg;

  int total = 0;
  int bad = 0;
  logic [31:0] ctrl_exp;
  logic [31:0] rd;

  always #4 clk = ~clk;

  cluster_reset_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_done(core_done), .core_rst_req(core_rst_req), .core_on_req(core_on_req),
    .core_off_req(core_off_req), .core_entry(core_entry), .core_arg(core_arg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rdw(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  task automatic ack(input int k);
    @(negedge clk);
    core_done[k] = 1'b1;
    @(negedge clk);
    core_done[k] = 1'b0;
  endtask

  task automatic chk_pulses(input string tag, input logic [3:0] r, input logic [3:0] on, input logic [3:0] off);
    chk({tag, " rst_req"}, 32'(core_rst_req), 32'(r));
    chk({tag, " on_req"},  32'(core_on_req),  32'(on));
    chk({tag, " off_req"}, 32'(core_off_req), 32'(off));
  endtask

  task automatic t_reset();
    rdw(12'h000, rd); chk("R3 ctrl init", rd, 32'h521);
    rdw(12'h008, rd); chk("R3 rstat init", rd, 32'h1);
    rdw(12'h018, rd); chk("R3 imask init", rd, 32'h1F);
    rdw(12'h004, rd); chk("R3 boot1 init", rd, 32'h0);
    rdw(12'h020, rd); chk("R3 gpr1 init", rd, 32'h0);
    chk_pulses("R3 idle", 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_plain();
    wr(12'h028, 32'h1000_0000);
    chk_pulses("R4 plain write", 4'h0, 4'h0, 4'h0);
    wr(12'h02C, 32'h0000_A5A5);
    wr(12'h030, 32'h2000_0040);
    wr(12'h034, 32'h0000_0077);
    wr(12'h00C, 32'hDEAD_BEEF);
    wr(12'h008, 32'h0000_0005);
    rdw(12'h028, rd); chk("R4 gpr3", rd, 32'h1000_0000);
    rdw(12'h00C, rd); chk("R4 spare", rd, 32'hDEAD_BEEF);
    rdw(12'h008, rd); chk("R4 rstat", rd, 32'h5);
  endtask

  task automatic t_access();
    wr(12'h029, 32'h1);
    rdw(12'h028, rd); chk("R1 misaligned write", rd, 32'h1000_0000);
    wr(12'h028, 32'h0, 4'h3);
    rdw(12'h028, rd); chk("R1 partial write", rd, 32'h1000_0000);
    rdw(12'h02A, rd); chk("R1 misaligned read", rd, 32'h0);
    rdw(12'h028, rd, 4'h1); chk("R1 partial read", rd, 32'h0);
    wr(12'h001, 32'hFFFF_FFFF);
    rdw(12'h000, rd); chk("R1 ctrl misaligned", rd, 32'h521);
  endtask

  task automatic t_range();
    wr(12'h044, 32'h0000_CAFE);
    rdw(12'h044, rd); chk("R2 gpr10", rd, 32'h0000_CAFE);
    wr(12'h048, 32'h1);
    rdw(12'h048, rd); chk("R2 beyond write", rd, 32'h0);
    rdw(12'hFFC, rd); chk("R2 top of window", rd, 32'h0);
  endtask

  task automatic t_start1();
    ctrl_exp = 32'h521 | (32'h1 << 22);
    wr(12'h000, ctrl_exp);
    chk_pulses("R7 core1 start", 4'h0, 4'h2, 4'h0);
    chk("R7 core1 entry", core_entry[32 +: 32], 32'h1000_0000);
    chk("R7 core1 arg", core_arg[32 +: 32], 32'h0000_A5A5);
    wr(12'h000, ctrl_exp | (32'h1 << 14));
    chk_pulses("R9 pending no retrigger", 4'h0, 4'h0, 4'h0);
    rdw(12'h000, rd); chk("R9 stored while pending", rd, ctrl_exp | (32'h1 << 14));
    ack(1);
    rdw(12'h000, rd); chk("R6 core1 bit cleared", rd, ctrl_exp);
    ack(1);
    rdw(12'h000, rd); chk("R9 stray done ignored", rd, ctrl_exp);
  endtask

  task automatic t_rst0();
    wr(12'h000, ctrl_exp | (32'h1 << 13));
    chk_pulses("R6 core0 reset", 4'h1, 4'h0, 4'h0);
    rdw(12'h000, rd); chk("R6 core0 bit held", rd, ctrl_exp | (32'h1 << 13));
    ack(0);
    rdw(12'h000, rd); chk("R6 core0 bit cleared", rd, ctrl_exp);
    wr(12'h000, ctrl_exp);
    chk_pulses("R10 unchanged write", 4'h0, 4'h0, 4'h0);
    wr(12'h000, ctrl_exp | (32'h1 << 16));
    chk_pulses("R6 core3 reset", 4'h8, 4'h0, 4'h0);
    ack(3);
    rdw(12'h000, rd); chk("R6 core3 bit cleared", rd, ctrl_exp);
  endtask

  task automatic t_en_rst2();
    ctrl_exp = ctrl_exp | (32'h1 << 23);
    wr(12'h000, ctrl_exp | (32'h1 << 15));
    chk_pulses("R8 enable masks reset", 4'h0, 4'h4, 4'h0);
    chk("R7 core2 entry", core_entry[64 +: 32], 32'h2000_0040);
    chk("R7 core2 arg", core_arg[64 +: 32], 32'h0000_0077);
    rdw(12'h000, rd); chk("R8 core2 bit stored", rd, ctrl_exp | (32'h1 << 15));
    ack(2);
    rdw(12'h000, rd); chk("R8 core2 bit cleared", rd, ctrl_exp);
  endtask

  task automatic t_off1();
    ctrl_exp = ctrl_exp & ~(32'h1 << 22);
    wr(12'h000, ctrl_exp);
    chk_pulses("R7 core1 stop", 4'h0, 4'h0, 4'h2);
    chk("R7 entry held", core_entry[32 +: 32], 32'h1000_0000);
    ack(1);
  endtask

  task automatic t_disp();
    wr(12'h000, ctrl_exp | (32'h1 << 3) | (32'h1 << 12));
    chk_pulses("R5 disp write", 4'h0, 4'h0, 4'h0);
    rdw(12'h000, rd); chk("R5 disp bits read 0", rd, ctrl_exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_access();
    t_range();
    t_start1();
    t_rst0();
    t_en_rst2();
    t_off1();
    t_disp();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule